// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

This block is one DMA channel that follows a ring of buffer descriptors kept in a small table inside the block. Each table entry holds five flags, a source base, a destination base and a word count. The flags are valid, interrupt, last, continuous and wrap. When software pulses `start`, the channel reads the entry at its current index. If the entry is valid, the channel copies `count` words from the source read port to the destination write port, one word per clock. The word on the destination side can be byte-reversed. When the entry is done, the channel updates its valid flag, posts status events and moves on to the next entry.

Every bus access carries a 4-bit address-type tag. The top bit is always high to mark a DMA access, and the three lower bits are the programmed source or destination code. On the very last word of a chain, both tags become all-ones. This tells the peripheral that the transfer has ended.

There are two event bits: an auxiliary event per descriptor and a chain-complete event. Each bit stays set until software writes a 1 to clear it. The two bits are masked and then combined into one interrupt line. Software fills the table through a write port, and can read any entry back through a combinational read port.

Top module: `desc_dma`

## Requirements
- R1: After reset the channel is idle (`busy` low). Both strobes are low, both address-type outputs are 0, `evtStatus` is 0 and `irq` is low.
- R2: A `start` pulse makes the channel fetch the entry at its current index. If that entry's valid flag (bit 0 of the descriptor word) is clear, the channel returns to idle with no data access. It fetches the same entry again on the next `start`.
- R3: A valid entry with count N>0 produces exactly N consecutive data cycles. In data cycle i, `srcRdEn` and `dstWrEn` are both high, `srcAddr` is source base + i and `dstAddr` is destination base + i. The descriptor word packs {dst base, src base, count, wrap(bit 4), cont(bit 3), last(bit 2), intr(bit 1), valid(bit 0)}, from the top bit down.
- R4: When `byteOrder` is 2'b01, `dstData` is `srcData` with its bytes in reverse order. For 2'b1x and 2'b00 it is passed unchanged. The value is captured when an entry is fetched, so a change during a transfer first applies to the next entry.
- R5: During a data cycle, `srcAt` is {1, `srcFc`} and `dstAt` is {1, `dstFc`}. Outside data cycles both are 0.
- R6: In the final data cycle of an entry whose last flag is set, `srcAt` and `dstAt` are both 4'hF.
- R7: When an entry with its intr flag set completes, `evtStatus[0]` (auxiliary event) is set. When the intr flag is clear, that entry does not set it.
- R8: When an entry with its last flag set completes, `evtStatus[1]` (chain-done event) is set whatever the intr flag is, and the channel returns to idle.
- R9: When an entry with its cont flag clear completes, its valid flag is cleared in the table. When the cont flag is set, the valid flag is left set.
- R10: After each entry completes, the index moves to the next entry, modulo the table depth. An entry with its wrap flag set sends the index to 0 instead. A non-last entry is followed at once by a fetch of the next entry.
- R11: Event bits stay set until `evtClr` has a 1 in that bit position. `irq` is high exactly when some event bit is set and its `evtMask` bit is 1.
- R12: A valid entry with count 0 completes with no data cycle. The intr, last, cont and wrap rules still apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins or resumes descriptor processing |
| descWrEn | input | 1 | Table write strobe |
| descWrIdx | input | IW | Table write index |
| descWrData | input | DESC_W | Descriptor word to write |
| descRdIdx | input | IW | Table read index |
| descRdData | output | DESC_W | Descriptor word at `descRdIdx` |
| srcFc | input | 3 | Source access code |
| dstFc | input | 3 | Destination access code |
| byteOrder | input | 2 | Byte-order select |
| evtMask | input | 2 | Interrupt mask per event bit |
| evtClr | input | 2 | Write-1-to-clear pulse per event bit |
| evtStatus | output | 2 | {chain-done, auxiliary} event bits |
| irq | output | 1 | Masked interrupt |
| busy | output | 1 | Channel not idle |
| srcRdEn | output | 1 | Source read strobe |
| srcAddr | output | AW | Source address |
| srcAt | output | 4 | Source address-type tag |
| srcData | input | DW | Source read data, valid in the same cycle |
| dstWrEn | output | 1 | Destination write strobe |
| dstAddr | output | AW | Destination address |
| dstAt | output | 4 | Destination address-type tag |
| dstData | output | DW | Destination write data |

## Verification
A wrong remaining-count or state register shows at once at the ports. It gives a data burst that is one word too long or too short, or an all-ones tag on the wrong word, within the same entry. A wrong latched byte order or address pointer corrupts every word of the current entry from its first data cycle. A wrong index or a missed valid-flag update may stay hidden until the next `start`. It then shows as the wrong base addresses in the next burst, or as a valid flag in the read-back table that should have changed. Because of this, the directed scenarios run back to back without a reset between them, so index and table state carry from one scenario to the next.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  typedef struct packed {
    logic wrap;
    logic cont;
    logic last;
    logic intr;
    logic valid;
  } descFlags_t;

  typedef struct packed {
    logic load;
    logic step;
    logic clrValid;
    logic finalCyc;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_DONE
  } chState_t;

endpackage

// File: rtl/desc_dma_dp.sv
module desc_dma_dp
  import desc_dma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int CW     = 8,
  parameter int DEPTH  = 4,
  parameter int IW     = 2,
  parameter int DESC_W = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IW-1:0]     idx,
  input  logic              descWrEn,
  input  logic [IW-1:0]     descWrIdx,
  input  logic [DESC_W-1:0] descWrData,
  input  logic [IW-1:0]     descRdIdx,
  output logic [DESC_W-1:0] descRdData,
  output descFlags_t        entFlags,
  output logic [CW-1:0]     entCount,
  input  logic [2:0]        srcFc,
  input  logic [2:0]        dstFc,
  input  logic [1:0]        byteOrder,
  output logic              srcRdEn,
  output logic [AW-1:0]     srcAddr,
  output logic [3:0]        srcAt,
  input  logic [DW-1:0]     srcData,
  output logic              dstWrEn,
  output logic [AW-1:0]     dstAddr,
  output logic [3:0]        dstAt,
  output logic [DW-1:0]     dstData
);

  localparam int NB      = DW / 8;
  localparam int CNT_LO  = 5;
  localparam int SRC_LO  = CNT_LO + CW;
  localparam int DST_LO  = SRC_LO + AW;

  logic [DESC_W-1:0] tbl [DEPTH];
  logic [AW-1:0]     srcPtr;
  logic [AW-1:0]     dstPtr;
  logic [1:0]        boCur;
  logic [DW-1:0]     swapped;

  // descriptor table: channel write-back first, software write has priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      if (strb.clrValid) tbl[idx][0] <= 1'b0;
      if (descWrEn) tbl[descWrIdx] <= descWrData;
    end
  end

  assign descRdData = tbl[descRdIdx];
  assign entFlags   = descFlags_t'(tbl[idx][4:0]);
  assign entCount   = tbl[idx][CNT_LO +: CW];

  // address pointers and byte order, captured per descriptor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
      boCur  <= 2'b10;
    end else if (strb.load) begin
      srcPtr <= tbl[idx][SRC_LO +: AW];
      dstPtr <= tbl[idx][DST_LO +: AW];
      boCur  <= byteOrder;
    end else if (strb.step) begin
      srcPtr <= srcPtr + 1'b1;
      dstPtr <= dstPtr + 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[8*b +: 8] = srcData[8*(NB-1-b) +: 8];
  end

  assign srcRdEn = strb.step;
  assign dstWrEn = strb.step;
  assign srcAddr = srcPtr;
  assign dstAddr = dstPtr;
  assign dstData = (boCur == 2'b01) ? swapped : srcData;

  always_comb begin
    srcAt = 4'h0;
    dstAt = 4'h0;
    if (strb.step) begin
      srcAt = strb.finalCyc ? 4'hF : {1'b1, srcFc};
      dstAt = strb.finalCyc ? 4'hF : {1'b1, dstFc};
    end
  end

  AST_CLR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrValid && !(descWrEn && descWrIdx == idx) |=> !tbl[$past(idx)][0]); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !strb.load |=> (srcAddr == $past(srcAddr) + 1'b1) && (dstAddr == $past(dstAddr) + 1'b1)); // R3
  AST_BO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && $past(strb.step) |-> $stable(boCur)); // R4
  AST_AT_MARK: assert property (@(posedge clk) disable iff (!rstN)
    srcRdEn |-> srcAt[3] && dstAt[3]); // R5

endmodule

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
#(
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  descFlags_t    entFlags,
  input  logic [CW-1:0] entCount,
  input  logic [1:0]    evtMask,
  input  logic [1:0]    evtClr,
  output dpStrobe_t     strb,
  output logic [IW-1:0] idx,
  output logic [1:0]    evtStatus,
  output logic          irq,
  output logic          busy
);

  chState_t      state;
  logic [CW-1:0] rem;
  logic          curIntr;
  logic          curLast;
  logic          curCont;
  logic          curWrap;
  logic [1:0]    evt;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_FETCH: strb.load = entFlags.valid;
      ST_XFER: begin
        strb.step     = 1'b1;
        strb.finalCyc = curLast && (rem == CW'(1));
      end
      ST_DONE:  strb.clrValid = !curCont;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      rem     <= '0;
      curIntr <= 1'b0;
      curLast <= 1'b0;
      curCont <= 1'b0;
      curWrap <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_FETCH;
        ST_FETCH: begin
          if (!entFlags.valid) begin
            state <= ST_IDLE;
          end else begin
            curIntr <= entFlags.intr;
            curLast <= entFlags.last;
            curCont <= entFlags.cont;
            curWrap <= entFlags.wrap;
            rem     <= entCount;
            state   <= (entCount == '0) ? ST_DONE : ST_XFER;
          end
        end
        ST_XFER: begin
          rem <= rem - 1'b1;
          if (rem == CW'(1)) state <= ST_DONE;
        end
        ST_DONE: begin
          if (curWrap || idx == IW'(DEPTH - 1)) idx <= '0;
          else idx <= idx + 1'b1;
          state <= curLast ? ST_IDLE : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sticky events, set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evt <= '0;
    end else begin
      evt <= (evt & ~evtClr) |
             ((state == ST_DONE) ? {curLast, curIntr} : 2'b00);
    end
  end

  assign evtStatus = evt;
  assign irq       = |(evt & evtMask);
  assign busy      = (state != ST_IDLE);

  AST_AD_EVT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE && curIntr |=> evtStatus[0]); // R7
  AST_DONE_EVT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE && curLast |=> evtStatus[1] && !busy); // R8
  AST_STOP_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH && !entFlags.valid |=> !busy && $stable(idx)); // R2
  AST_WRAP_IDX: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE && curWrap |=> idx == '0); // R10
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH && entFlags.valid && entCount == '0 |=> state == ST_DONE); // R12
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    evtStatus[0] && !evtClr[0] |=> evtStatus[0]); // R11

endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import desc_dma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DESC_W = 5 + CW + 2 * AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              descWrEn,
  input  logic [IW-1:0]     descWrIdx,
  input  logic [DESC_W-1:0] descWrData,
  input  logic [IW-1:0]     descRdIdx,
  output logic [DESC_W-1:0] descRdData,
  input  logic [2:0]        srcFc,
  input  logic [2:0]        dstFc,
  input  logic [1:0]        byteOrder,
  input  logic [1:0]        evtMask,
  input  logic [1:0]        evtClr,
  output logic [1:0]        evtStatus,
  output logic              irq,
  output logic              busy,
  output logic              srcRdEn,
  output logic [AW-1:0]     srcAddr,
  output logic [3:0]        srcAt,
  input  logic [DW-1:0]     srcData,
  output logic              dstWrEn,
  output logic [AW-1:0]     dstAddr,
  output logic [3:0]        dstAt,
  output logic [DW-1:0]     dstData
);

  dpStrobe_t     strb;
  logic [IW-1:0] idx;
  descFlags_t    entFlags;
  logic [CW-1:0] entCount;

  desc_dma_ctrl #(.CW(CW), .DEPTH(DEPTH), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .entFlags(entFlags), .entCount(entCount),
    .evtMask(evtMask), .evtClr(evtClr),
    .strb(strb), .idx(idx),
    .evtStatus(evtStatus), .irq(irq), .busy(busy)
  );

  desc_dma_dp #(.DW(DW), .AW(AW), .CW(CW), .DEPTH(DEPTH), .IW(IW), .DESC_W(DESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWrData(descWrData),
    .descRdIdx(descRdIdx), .descRdData(descRdData),
    .entFlags(entFlags), .entCount(entCount),
    .srcFc(srcFc), .dstFc(dstFc), .byteOrder(byteOrder),
    .srcRdEn(srcRdEn), .srcAddr(srcAddr), .srcAt(srcAt), .srcData(srcData),
    .dstWrEn(dstWrEn), .dstAddr(dstAddr), .dstAt(dstAt), .dstData(dstData)
  );

endmodule

// File: tb/sim_desc_dma.sv
`timescale 1ns/1ps
module sim_desc_dma;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DEPTH = 4;
  localparam int IW = 2;
  localparam int DESC_W = 5 + CW + 2 * AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic descWrEn = 1'b0;
  logic [IW-1:0] descWrIdx = '0;
  logic [DESC_W-1:0] descWrData = '0;
  logic [IW-1:0] descRdIdx = '0;
  logic [DESC_W-1:0] descRdData;
  logic [2:0] srcFc = 3'b010;
  logic [2:0] dstFc = 3'b101;
  logic [1:0] byteOrder = 2'b10;
  logic [1:0] evtMask = 2'b00;
  logic [1:0] evtClr = 2'b00;
  logic [1:0] evtStatus;
  logic irq, busy, srcRdEn, dstWrEn;
  logic [AW-1:0] srcAddr, dstAddr;
  logic [3:0] srcAt, dstAt;
  logic [DW-1:0] srcData, dstData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [AW-1:0] lSrc [64];
  logic [AW-1:0] lDst [64];
  logic [DW-1:0] lData [64];
  logic [3:0] lSat [64];
  logic [3:0] lDat [64];
  int logN = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {a, a ^ 8'hFF, 8'h5A, a + 8'h11};
  endfunction

  function automatic logic [DW-1:0] swapW(input logic [DW-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [DESC_W-1:0] mkDesc(input logic v, input logic it, input logic la,
      input logic co, input logic wr, input logic [CW-1:0] cnt,
      input logic [AW-1:0] s, input logic [AW-1:0] d);
    return {d, s, cnt, wr, co, la, it, v};
  endfunction

  assign srcData = memWord(srcAddr);

  desc_dma u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWrData(descWrData),
    .descRdIdx(descRdIdx), .descRdData(descRdData),
    .srcFc(srcFc), .dstFc(dstFc), .byteOrder(byteOrder),
    .evtMask(evtMask), .evtClr(evtClr), .evtStatus(evtStatus),
    .irq(irq), .busy(busy),
    .srcRdEn(srcRdEn), .srcAddr(srcAddr), .srcAt(srcAt), .srcData(srcData),
    .dstWrEn(dstWrEn), .dstAddr(dstAddr), .dstAt(dstAt), .dstData(dstData)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (dstWrEn && logN < 64) begin
      lSrc[logN]  <= srcAddr;
      lDst[logN]  <= dstAddr;
      lData[logN] <= dstData;
      lSat[logN]  <= srcAt;
      lDat[logN]  <= dstAt;
      logN <= logN + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeDesc(input int i, input logic [DESC_W-1:0] d);
    @(negedge clk);
    descWrEn = 1'b1; descWrIdx = IW'(i); descWrData = d;
    @(negedge clk);
    descWrEn = 1'b0;
  endtask

  task automatic validOf(input int i, output logic v);
    descRdIdx = IW'(i);
    #1;
    v = descRdData[0];
  endtask

  task automatic pulseClr(input logic [1:0] m);
    @(negedge clk);
    evtClr = m;
    @(negedge clk);
    evtClr = 2'b00;
    @(negedge clk);
  endtask

  task automatic runChain();
    @(negedge clk);
    logN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {srcRdEn, dstWrEn}, 0);
    chk("R1 at", {srcAt, dstAt}, 0);
    chk("R1 evt", evtStatus, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic testChain();
    logic v;
    writeDesc(0, mkDesc(1, 1, 0, 0, 0, 3, 8'h10, 8'h40));
    writeDesc(1, mkDesc(1, 0, 1, 1, 0, 2, 8'h20, 8'h60));
    runChain();
    chk("R3 word count", logN, 5);
    for (int i = 0; i < 5; i++) begin
      logic [AW-1:0] s = (i < 3) ? AW'(8'h10 + i) : AW'(8'h20 + i - 3);
      logic [AW-1:0] d = (i < 3) ? AW'(8'h40 + i) : AW'(8'h60 + i - 3);
      chk("R3 src addr", lSrc[i], s);
      chk("R3 dst addr", lDst[i], d);
      chk("R4 data pass", lData[i], memWord(s));
      chk("R5 R6 src at", lSat[i], (i == 4) ? 4'hF : 4'hA);
      chk("R5 R6 dst at", lDat[i], (i == 4) ? 4'hF : 4'hD);
    end
    chk("R7 R8 evt", evtStatus, 2'b11);
    chk("R8 idle", busy, 0);
    chk("R5 idle at", {srcAt, dstAt}, 0);
    validOf(0, v); chk("R9 valid cleared", v, 0);
    validOf(1, v); chk("R9 valid kept", v, 1);
    evtMask = 2'b00; #1; chk("R11 irq masked", irq, 0);
    evtMask = 2'b10; #1; chk("R11 irq done", irq, 1);
    pulseClr(2'b01);
    chk("R11 clear aux only", evtStatus, 2'b10);
    evtMask = 2'b01; #1; chk("R11 irq aux masked", irq, 0);
    pulseClr(2'b10);
    chk("R11 clear done", evtStatus, 2'b00);
    evtMask = 2'b00;
  endtask

  task automatic testInvalidResume();
    runChain();
    chk("R2 no access", logN, 0);
    chk("R2 stopped", busy, 0);
    chk("R2 no event", evtStatus, 0);
    writeDesc(2, mkDesc(1, 0, 1, 0, 0, 1, 8'h50, 8'h58));
    runChain();
    chk("R2 resume count", logN, 1);
    chk("R2 resume addr", lSrc[0], 8'h50);
    chk("R6 single final at", {lSat[0], lDat[0]}, 8'hFF);
    chk("R7 no aux R8 done", evtStatus, 2'b10);
    pulseClr(2'b11);
  endtask

  task automatic testWrapZero();
    logic v;
    writeDesc(3, mkDesc(1, 1, 0, 1, 1, 0, 8'hC0, 8'hC8));
    writeDesc(0, mkDesc(1, 0, 1, 0, 0, 2, 8'h80, 8'h88));
    runChain();
    chk("R12 zero no data", logN, 2);
    chk("R10 wrap to 0", lSrc[0], 8'h80);
    chk("R10 wrap dst", lDst[1], 8'h89);
    chk("R6 last word at", lSat[1], 4'hF);
    chk("R12 R7 aux from zero", evtStatus, 2'b11);
    validOf(3, v); chk("R12 R9 cont kept", v, 1);
    validOf(0, v); chk("R9 chain cleared", v, 0);
    pulseClr(2'b11);
  endtask

  task automatic testByteOrder();
    writeDesc(1, mkDesc(1, 0, 0, 0, 0, 4, 8'h30, 8'h70));
    writeDesc(2, mkDesc(1, 0, 1, 0, 0, 2, 8'h90, 8'hA0));
    byteOrder = 2'b10;
    @(negedge clk);
    logN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    byteOrder = 2'b01;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R10 advance count", logN, 6);
    chk("R10 next entry", lSrc[0], 8'h30);
    for (int i = 0; i < 4; i++)
      chk("R4 old order held", lData[i], memWord(AW'(8'h30 + i)));
    for (int i = 0; i < 2; i++)
      chk("R4 swapped next", lData[4 + i], swapW(memWord(AW'(8'h90 + i))));
    byteOrder = 2'b10;
    pulseClr(2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChain();
    testInvalidResume();
    testWrapZero();
    testByteOrder();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule